// File: doc/BRIEF.md
# Interrupt context stacking sequencer

This block sits beside a small 8-bit CPU core and handles the register traffic for entering and leaving an interrupt. When the core signals an instruction boundary and an interrupt is pending and not masked, the sequencer takes a copy of the whole register set and writes it, one byte per clock, to a stack that grows downward in memory. It then reads a two-byte handler address from a fixed location and loads the program counter with it. It also sets the live interrupt mask so that a second request cannot nest.

On a return request the sequencer reads the same nine bytes back in the mirror order. In the cycle of the final read it writes every register back to the core at once, and execution resumes at the restored address. The stack pointer belongs to the sequencer. Instruction decode and arithmetic stay in the core.

Top module: `ctx_stacker`

## Requirements
- R1: An interrupt is accepted only in a clock where the sequencer is idle, `insn_boundary` is high, `irq_req` is high, bit I_BIT (default 4) of `ccr_in` is 0, and `rti_req` is low. In any other case the request has no effect: no memory write occurs and `busy` stays low.
- R2: Starting the cycle after acceptance, nine consecutive cycles each assert `mem_we` with one byte of the captured context. The order is PC[7:0], PC[15:8], Y[7:0], Y[15:8], X[7:0], X[15:8], A, B, CCR.
- R3: The stack pointer `sp_o` addresses the next free byte. Each push writes at `sp_o` and then decrements it. Each pull first increments it and reads at the new value. After reset it equals SP_TOP, and a full entry followed by a full return leaves it unchanged.
- R4: After the ninth push the sequencer reads VEC_ADDR and then VEC_ADDR+1 in two consecutive cycles. In the second cycle `pc_wr_en` is high and `pc_wr_data` is {byte at VEC_ADDR, byte at VEC_ADDR+1}.
- R5: The CCR byte written to the stack holds the value from before the interrupt. In the vector-load cycle `ccr_wr_en` is high and `ccr_wr_data` equals that value with bit I_BIT set.
- R6: When `rti_req` is high while the sequencer is idle, nine consecutive reads follow at ascending addresses sp_o+1 … sp_o+9. These return the bytes in the reverse of the R2 order.
- R7: In the ninth pull cycle `pc_wr_en`, `ccr_wr_en` and `rf_wr_en` are high together, and the write-back outputs carry exactly the pushed values of PC, Y, X, A, B and CCR.
- R8: `busy` is high from the first push cycle through the vector-load cycle, and from the first pull cycle through the last pull cycle. It is low at all other times.
- R9: If a return request and a qualifying interrupt arrive in the same idle cycle, the return is started and the interrupt is not.
- R10: `irq_req` and `rti_req` have no effect while `busy` is high. One request produces exactly one frame of nine bytes.
- R11: The memory port never asserts `mem_we` and `mem_re` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | Core has just completed an instruction |
| irq_req | input | 1 | Pending interrupt request |
| rti_req | input | 1 | Return-from-interrupt request |
| pc_in | input | 16 | Live program counter |
| y_in | input | 16 | Live Y index register |
| x_in | input | 16 | Live X index register |
| a_in | input | 8 | Live accumulator A |
| b_in | input | 8 | Live accumulator B |
| ccr_in | input | 8 | Live condition code register (bit I_BIT is the mask) |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| pc_wr_en | output | 1 | Load the program counter |
| pc_wr_data | output | 16 | New program counter value |
| ccr_wr_en | output | 1 | Load the condition code register |
| ccr_wr_data | output | 8 | New condition code value |
| rf_wr_en | output | 1 | Load Y, X, A and B |
| y_wr_data | output | 16 | Restored Y |
| x_wr_data | output | 16 | Restored X |
| a_wr_data | output | 8 | Restored A |
| b_wr_data | output | 8 | Restored B |
| busy | output | 1 | Context transfer in progress |
| sp_o | output | AW | Current stack pointer |

## Verification
A return request and an unmasked interrupt can both arrive in one idle cycle. The bench causes this by clearing the mask in its core model after an entry, then raising both requests at an instruction boundary. It then checks the first cycle, which must be a read at sp_o+1 and not a write at sp_o. It also checks that the restored registers and the stack pointer match the values from before the entry, which shows that no extra frame was pushed. A request held high through an entire transfer is a second kind of overlap. In that case the bench checks that exactly nine bytes move and that the stack pointer ends nine below or back at the top.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam int FRAME_BYTES = 9;
  localparam int IDX_W       = 4;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VHI,
    ST_VLO,
    ST_PULL
  } seq_t;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] y;
    logic [15:0] x;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  ccr;
  } ctx_t;

  // Byte k of the stacked frame, k = 0 is pushed first.
  function automatic logic [7:0] frame_byte(ctx_t c, logic [IDX_W-1:0] k);
    logic [7:0] r;
    case (k)
      4'd0:    r = c.pc[7:0];
      4'd1:    r = c.pc[15:8];
      4'd2:    r = c.y[7:0];
      4'd3:    r = c.y[15:8];
      4'd4:    r = c.x[7:0];
      4'd5:    r = c.x[15:8];
      4'd6:    r = c.a;
      4'd7:    r = c.b;
      4'd8:    r = c.ccr;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] mask_on(logic [7:0] ccr, int unsigned bitpos);
    return ccr | (8'h01 << bitpos);
  endfunction

endpackage

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_irq,
  input  logic             start_rti,
  output logic             idle,
  output logic             ph_push,
  output logic             ph_vhi,
  output logic             ph_vlo,
  output logic             ph_pull,
  output logic             pull_last,
  output logic [IDX_W-1:0] idx
);

  seq_t st_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_rti) begin
            st_q  <= ST_PULL;
            idx_q <= LAST_IDX;
          end else if (start_irq) begin
            st_q  <= ST_PUSH;
            idx_q <= '0;
          end
        end
        ST_PUSH: begin
          if (idx_q == LAST_IDX) st_q <= ST_VHI;
          else                   idx_q <= idx_q + 1'b1;
        end
        ST_VHI:  st_q <= ST_VLO;
        ST_VLO:  st_q <= ST_IDLE;
        ST_PULL: begin
          if (idx_q == '0) st_q <= ST_IDLE;
          else             idx_q <= idx_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign ph_push   = (st_q == ST_PUSH);
  assign ph_vhi    = (st_q == ST_VHI);
  assign ph_vlo    = (st_q == ST_VLO);
  assign ph_pull   = (st_q == ST_PULL);
  assign pull_last = ph_pull && (idx_q == '0);
  assign idx       = idx_q;

endmodule

// File: rtl/ctx_sp.sv
module ctx_sp #(
  parameter int          AW     = 16,
  parameter logic [AW-1:0] SP_TOP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up
);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_TOP;
    else if (dec) sp_q <= sp_q - 1'b1;
    else if (inc) sp_q <= sp_q + 1'b1;
  end

  assign sp    = sp_q;
  assign sp_up = sp_q + 1'b1;

endmodule

// File: rtl/ctx_frame.sv
module ctx_frame
  import ctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  ctx_t             live,
  input  logic [IDX_W-1:0] idx,
  input  logic             ph_pull,
  input  logic             ph_vhi,
  input  logic [7:0]       rdata,
  output logic [7:0]       push_byte,
  output logic [7:0]       saved_ccr,
  output logic [7:0]       vec_hi,
  output ctx_t             restored
);

  ctx_t       snap_q;
  logic [7:0] vhi_q;
  logic [7:0] pb [1:FRAME_BYTES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      vhi_q  <= '0;
    end else begin
      if (capture) snap_q <= live;
      if (ph_vhi)  vhi_q  <= rdata;
    end
  end

  for (genvar g = 1; g < FRAME_BYTES; g++) begin : g_pull
    always_ff @(posedge clk) begin
      if (!rst_n)                                pb[g] <= '0;
      else if (ph_pull && idx == IDX_W'(g))      pb[g] <= rdata;
    end
  end

  assign push_byte = frame_byte(snap_q, idx);
  assign saved_ccr = snap_q.ccr;
  assign vec_hi    = vhi_q;

  always_comb begin
    restored.pc  = {pb[1], rdata};
    restored.y   = {pb[3], pb[2]};
    restored.x   = {pb[5], pb[4]};
    restored.a   = pb[6];
    restored.b   = pb[7];
    restored.ccr = pb[8];
  end

endmodule

// File: rtl/ctx_stacker.sv
module ctx_stacker
  import ctx_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] SP_TOP   = AW'(16'h00FF),
  parameter logic [AW-1:0] VEC_ADDR = AW'(16'hFFF6),
  parameter int            I_BIT    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_boundary,
  input  logic          irq_req,
  input  logic          rti_req,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   y_in,
  input  logic [15:0]   x_in,
  input  logic [7:0]    a_in,
  input  logic [7:0]    b_in,
  input  logic [7:0]    ccr_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          pc_wr_en,
  output logic [15:0]   pc_wr_data,
  output logic          ccr_wr_en,
  output logic [7:0]    ccr_wr_data,
  output logic          rf_wr_en,
  output logic [15:0]   y_wr_data,
  output logic [15:0]   x_wr_data,
  output logic [7:0]    a_wr_data,
  output logic [7:0]    b_wr_data,
  output logic          busy,
  output logic [AW-1:0] sp_o
);

  localparam logic [AW-1:0] VEC_LO_ADDR = VEC_ADDR + AW'(1);

  logic             idle, ph_push, ph_vhi, ph_vlo, ph_pull, pull_last;
  logic [IDX_W-1:0] idx;
  logic             start_irq, start_rti;
  logic [AW-1:0]    sp_q, sp_up;
  logic [7:0]       push_byte, saved_ccr, vec_hi;
  ctx_t             live, restored;

  assign live      = '{pc: pc_in, y: y_in, x: x_in, a: a_in, b: b_in, ccr: ccr_in};
  assign start_rti = idle && rti_req;
  assign start_irq = idle && insn_boundary && irq_req && !ccr_in[I_BIT] && !rti_req;

  ctx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_irq (start_irq),
    .start_rti (start_rti),
    .idle      (idle),
    .ph_push   (ph_push),
    .ph_vhi    (ph_vhi),
    .ph_vlo    (ph_vlo),
    .ph_pull   (ph_pull),
    .pull_last (pull_last),
    .idx       (idx)
  );

  ctx_sp #(.AW(AW), .SP_TOP(SP_TOP)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (ph_push),
    .inc   (ph_pull),
    .sp    (sp_q),
    .sp_up (sp_up)
  );

  ctx_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (start_irq),
    .live      (live),
    .idx       (idx),
    .ph_pull   (ph_pull),
    .ph_vhi    (ph_vhi),
    .rdata     (mem_rdata),
    .push_byte (push_byte),
    .saved_ccr (saved_ccr),
    .vec_hi    (vec_hi),
    .restored  (restored)
  );

  always_comb begin
    if (ph_push)      mem_addr = sp_q;
    else if (ph_pull) mem_addr = sp_up;
    else if (ph_vlo)  mem_addr = VEC_LO_ADDR;
    else              mem_addr = VEC_ADDR;
  end

  assign mem_we    = ph_push;
  assign mem_re    = ph_vhi || ph_vlo || ph_pull;
  assign mem_wdata = ph_push ? push_byte : 8'h00;

  assign pc_wr_en    = ph_vlo || pull_last;
  assign pc_wr_data  = ph_vlo ? {vec_hi, mem_rdata} : restored.pc;
  assign ccr_wr_en   = ph_vlo || pull_last;
  assign ccr_wr_data = ph_vlo ? mask_on(saved_ccr, I_BIT) : restored.ccr;
  assign rf_wr_en    = pull_last;
  assign y_wr_data   = restored.y;
  assign x_wr_data   = restored.x;
  assign a_wr_data   = restored.a;
  assign b_wr_data   = restored.b;

  assign busy = !idle;
  assign sp_o = sp_q;

endmodule

// File: rtl/ctx_stacker_chk.sv
module ctx_stacker_chk #(
  parameter int AW    = 16,
  parameter int I_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_boundary,
  input logic          irq_req,
  input logic [7:0]    ccr_in,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp,
  input logic          ph_pull,
  input logic          busy,
  input logic          pc_wr_en,
  input logic          ccr_wr_en,
  input logic [7:0]    ccr_wr_data,
  input logic          rf_wr_en,
  input logic          start_irq,
  input logic          start_rti
);

  a_r11_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 1'b1);

  a_r6_pull_above: assert property (@(posedge clk) disable iff (!rst_n)
    ph_pull |-> mem_addr == sp + 1'b1);

  a_r1_entry_gate: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq |-> insn_boundary && irq_req && !ccr_in[I_BIT] && !busy);

  a_r9_rti_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_rti |-> !start_irq);

  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_en && !rf_wr_en) |-> ccr_wr_en && ccr_wr_data[I_BIT]);

  a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pc_wr_en));

  a_r7_restore_all: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> pc_wr_en && ccr_wr_en && busy);

endmodule

bind ctx_stacker ctx_stacker_chk #(.AW(AW), .I_BIT(I_BIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .irq_req       (irq_req),
  .ccr_in        (ccr_in),
  .mem_we        (mem_we),
  .mem_re        (mem_re),
  .mem_addr      (mem_addr),
  .sp            (sp_q),
  .ph_pull       (ph_pull),
  .busy          (busy),
  .pc_wr_en      (pc_wr_en),
  .ccr_wr_en     (ccr_wr_en),
  .ccr_wr_data   (ccr_wr_data),
  .rf_wr_en      (rf_wr_en),
  .start_irq     (start_irq),
  .start_rti     (start_rti)
);

// File: tb/ctx_stacker_bench.sv
module ctx_stacker_bench;

  localparam logic [15:0] TOP = 16'h00FF;
  localparam logic [15:0] VEC = 16'hFFF6;
  localparam int          IB  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_boundary = 1'b0, irq_req = 1'b0, rti_req = 1'b0;
  logic [15:0] c_pc = '0, c_y = '0, c_x = '0;
  logic [7:0]  c_a = '0, c_b = '0, c_ccr = '0;
  logic [15:0] mem_addr, pc_wr_data, y_wr_data, x_wr_data, sp_o;
  logic        mem_we, mem_re, pc_wr_en, ccr_wr_en, rf_wr_en, busy;
  logic [7:0]  mem_wdata, mem_rdata, ccr_wr_data, a_wr_data, b_wr_data;
  logic [7:0]  vhi = 8'h00, vlo = 8'h00;
  logic [7:0]  ram [0:255];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ctx_stacker u_ctx_stacker (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .irq_req(irq_req),
    .rti_req(rti_req), .pc_in(c_pc), .y_in(c_y), .x_in(c_x), .a_in(c_a),
    .b_in(c_b), .ccr_in(c_ccr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .ccr_wr_en(ccr_wr_en),
    .ccr_wr_data(ccr_wr_data), .rf_wr_en(rf_wr_en), .y_wr_data(y_wr_data),
    .x_wr_data(x_wr_data), .a_wr_data(a_wr_data), .b_wr_data(b_wr_data),
    .busy(busy), .sp_o(sp_o)
  );

  always_comb begin
    if (mem_addr == VEC)                mem_rdata = vhi;
    else if (mem_addr == VEC + 16'd1)   mem_rdata = vlo;
    else                                mem_rdata = ram[mem_addr[7:0]];
  end

  // Core model and memory model.
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (pc_wr_en)  c_pc  <= pc_wr_data;
    if (ccr_wr_en) c_ccr <= ccr_wr_data;
    if (rf_wr_en) begin
      c_y <= y_wr_data; c_x <= x_wr_data; c_a <= a_wr_data; c_b <= b_wr_data;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic [71:0] frame, int k);
    return 8'(frame >> (8 * k));
  endfunction

  // Entry: checks R2, R3, R4, R5, R8, R10 (hold keeps irq_req high throughout).
  task automatic do_entry(input bit hold);
    logic [71:0] fr;
    logic [7:0]  ccr0;
    fr   = {c_ccr, c_b, c_a, c_x[15:8], c_x[7:0], c_y[15:8], c_y[7:0], c_pc[15:8], c_pc[7:0]};
    ccr0 = c_ccr;
    @(negedge clk);
    irq_req = 1'b1; insn_boundary = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (!hold) irq_req = 1'b0;
      chk(mem_we && !mem_re, "R2 push strobe", {30'd0, mem_we, mem_re}, 32'd2);
      chk(mem_addr == TOP - 16'(k), "R3 push address", mem_addr, TOP - 16'(k));
      chk(mem_wdata == exp_byte(fr, k), "R2 push byte", mem_wdata, exp_byte(fr, k));
      chk(busy, "R8 busy during push", busy, 1);
    end
    @(negedge clk);
    chk(mem_re && mem_addr == VEC, "R4 vector high read", mem_addr, VEC);
    @(negedge clk);
    chk(mem_re && mem_addr == VEC + 16'd1, "R4 vector low read", mem_addr, VEC + 16'd1);
    chk(pc_wr_en && pc_wr_data == {vhi, vlo}, "R4 vector load", pc_wr_data, {vhi, vlo});
    chk(ccr_wr_en && ccr_wr_data == (ccr0 | 8'h10), "R5 mask set", ccr_wr_data, ccr0 | 8'h10);
    chk(busy && !rf_wr_en, "R8 busy at vector load", busy, 1);
    @(negedge clk);
    irq_req = 1'b0; insn_boundary = 1'b0;
    chk(!busy, "R8 busy released", busy, 0);
    chk(sp_o == TOP - 16'd9, "R10 one frame pushed", sp_o, TOP - 16'd9);
    chk(ram[8'(TOP - 16'd8)] == ccr0, "R5 stacked ccr pre-value", ram[8'(TOP - 16'd8)], ccr0);
  endtask

  // Return: checks R6, R7, R8, R3, R10 (rti_req held mid-pull), R9 when collide.
  task automatic do_return(input bit collide, input logic [15:0] pc0, input logic [15:0] y0,
                           input logic [15:0] x0, input logic [7:0] a0, input logic [7:0] b0,
                           input logic [7:0] ccr0);
    @(negedge clk);
    rti_req = 1'b1;
    if (collide) begin
      irq_req = 1'b1; insn_boundary = 1'b1;
    end
    @(posedge clk);
    for (int j = 0; j < 9; j++) begin
      @(negedge clk);
      irq_req = 1'b0; insn_boundary = 1'b0;
      if (j == 4) rti_req = 1'b0;
      if (j == 0 && collide)
        chk(mem_re && !mem_we, "R9 return wins", {30'd0, mem_we, mem_re}, 32'd1);
      chk(mem_re && !mem_we && mem_addr == TOP - 16'd8 + 16'(j), "R6 pull address",
          mem_addr, TOP - 16'd8 + 16'(j));
      chk(busy, "R8 busy during pull", busy, 1);
      chk(rf_wr_en == (j == 8), "R7 write-back timing", rf_wr_en, (j == 8));
    end
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R8 idle after pull", busy, 0);
    chk(sp_o == TOP, "R3 stack pointer restored", sp_o, TOP);
    chk(c_pc == pc0, "R7 PC restored", c_pc, pc0);
    chk({c_y, c_x} == {y0, x0}, "R7 index restored", {c_y, c_x}, {y0, x0});
    chk({c_a, c_b, c_ccr} == {a0, b0, ccr0}, "R7 acc/ccr restored", {c_a, c_b, c_ccr},
        {a0, b0, ccr0});
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R8 reset idle", busy, 0);
    chk(sp_o == TOP, "R3 reset pointer", sp_o, TOP);

    for (int n = 0; n < 16; n++) begin
      logic [15:0] pc0, y0, x0;
      logic [7:0]  a0, b0, ccr0;
      pc0  = 16'h1000 + 16'(n * 16'h0123);
      y0   = 16'hA55A ^ 16'(n * 16'h0F31);
      x0   = 16'h3C00 + 16'(n * 16'h0107);
      a0   = 8'(n * 17 + 3);
      b0   = 8'(255 - n * 13);
      ccr0 = 8'(n * 37) & 8'hEF;
      vhi  = 8'hE0 + 8'(n);
      vlo  = 8'(n * 11);
      c_pc = pc0; c_y = y0; c_x = x0; c_a = a0; c_b = b0; c_ccr = ccr0;

      // R1: request without a boundary is ignored.
      @(negedge clk);
      irq_req = 1'b1; insn_boundary = 1'b0;
      repeat (2) @(negedge clk);
      chk(!busy && !mem_we && sp_o == TOP, "R1 no boundary ignored", sp_o, TOP);
      irq_req = 1'b0;

      do_entry(n[0]);
      chk(c_pc == {vhi, vlo}, "R4 core pc from vector", c_pc, {vhi, vlo});

      // R1: masked request (I set after entry) is ignored.
      @(negedge clk);
      irq_req = 1'b1; insn_boundary = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_we && sp_o == TOP - 16'd9, "R1 masked ignored", sp_o, TOP - 16'd9);
      irq_req = 1'b0; insn_boundary = 1'b0;

      if (n[1]) c_ccr = c_ccr & 8'hEF;   // handler clears mask: provoke R9 collision
      do_return(n[1], pc0, y0, x0, a0, b0, ccr0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule